// File: doc/BRIEF.md
# Link Rate Matching ALIGN Inserter

This block lives in the transmit path of a serial storage port, between the frame/dword source and the encoder. It forwards an incoming dword stream and places ALIGN primitives into that stream. This lets the effective payload rate drop to the slowest physical link on the pathway to the far end. It takes the slowest rate over every hop on that path, including links between expanders and the destination link. It compares that rate with the local transmit rate and follows each data dword with (ratio − 1) ALIGNs. For example, a 6.0 Gbps transmitter facing a 1.5 Gbps link pads each dword with three ALIGNs.

On top of the rate padding, the block places one ALIGN every `CC_PERIOD` output dwords (2048 by default) for clock compensation. Rate information comes from configuration that software derives from the known topology. The block samples it once per connection, on a start pulse. The input uses a valid/ready handshake. Ready is withheld whenever an ALIGN is being produced, so every accepted dword leaves exactly once. The output is a registered dword stream with a flag that marks inserted primitives.

Top module: `rlm_align_inserter`

## Requirements
- R1: The pacing rate is the minimum over all hop codes in `path_rates`, where hop i occupies bits [2i+1:2i]. The codes are 0 = 1.5 Gbps, 1 = 3.0 Gbps, 2 = 6.0 Gbps and 3 = hop not present. A code of 3 never lowers the pacing rate.
- R2: The pad count is 2^(tx − slowest) − 1 when the local rate `tx_rate` is faster than the pacing rate, and 0 otherwise. This gives 3 for 6.0 over 1.5, and 1 for 6.0 over 3.0 or for 3.0 over 1.5. A `tx_rate` code of 3 acts as 6.0 Gbps. If no hop is present, the pad count is 0.
- R3: An input dword accepted with `in_valid` and `in_ready` high appears on `out_data` in the next cycle, with `out_valid` = 1 and `out_align` = 0. Exactly pad-count ALIGN dwords follow it, each with `out_valid` = 1, `out_align` = 1 and `out_data` = `ALIGN_WORD`.
- R4: `in_ready` is low in every cycle in which an ALIGN is being produced. Data dwords leave in input order, with none lost or repeated.
- R5: A clock-compensation ALIGN is emitted after `CC_PERIOD` − 1 other output dwords. Padding ALIGNs count toward this total. With a pad count of 0, the ALIGNs sit at output positions `CC_PERIOD` − 1, 2·`CC_PERIOD` − 1, and so on, counted from the connection start.
- R6: When the clock-compensation ALIGN falls due during a padding run, it is emitted right after that run. That data dword is then followed by pad-count + 1 ALIGNs. All other data dwords keep the normal pad count.
- R7: `tx_rate` and `path_rates` are sampled only in a cycle with `conn_start` = 1. Changes at any other time have no effect until the next start. A start also clears the padding and interval counters.
- R8: After the synchronous active-high `rst`, `out_valid` is 0 and `in_ready` stays 0 until the first `conn_start`. The interval and padding counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conn_start | input | 1 | One-cycle pulse: new connection, sample rates |
| tx_rate | input | 2 | Local transmit rate code |
| path_rates | input | 2·N_HOPS | Rate codes of every hop on the pathway |
| in_valid | input | 1 | Input dword valid |
| in_data | input | DATA_W | Input dword |
| in_ready | output | 1 | Block can take an input dword this cycle |
| out_valid | output | 1 | Output dword valid |
| out_data | output | DATA_W | Output dword |
| out_align | output | 1 | Output dword is an inserted ALIGN |

## Verification
Padding is exercised with hop lists whose minimum sits at different positions, with absent hops mixed in, and with the local rate below, equal to and above the pacing rate. Pad counts of 3, 1 and 0 are all covered, which separates a wrong minimum from a wrong ratio. Long continuous streams with pad counts 0 and 3 place the compensation ALIGN at a fixed slot or defer it past a padding run. This separates correct counting of pads toward the interval from counting data alone. A stream configured one way and then reconfigured mid-connection shows whether the rates are latched only at the start.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
   localparam int RATE_W = 2;
   localparam int PAD_W  = 2;

   typedef logic [RATE_W-1:0] rate_t;

   localparam rate_t RATE_1G5   = 2'd0;
   localparam rate_t RATE_3G0   = 2'd1;
   localparam rate_t RATE_6G0   = 2'd2;
   localparam rate_t RATE_NONE  = 2'd3;

   // ALIGNs per data dword for a transmit rate over a pacing rate
   function automatic logic [PAD_W-1:0] pad_for(input rate_t tx, input rate_t slow);
      rate_t tx_e;
      rate_t diff;
      tx_e = (tx == RATE_NONE) ? RATE_6G0 : tx;
      if (slow >= tx_e) return '0;
      diff = tx_e - slow;
      case (diff)
         2'd1:    return 2'd1;
         2'd2:    return 2'd3;
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/rlm_slowest_rate.sv
module rlm_slowest_rate
   import rlm_pkg::*;
#(
   parameter int N_HOPS = 4
) (
   input  logic [N_HOPS*RATE_W-1:0] hop_rates,
   output rate_t                    slowest
);
   generate
      if (N_HOPS == 1) begin : g_single
         assign slowest = hop_rates[RATE_W-1:0];
      end else begin : g_chain
         rate_t run [N_HOPS+1];
         assign run[0] = RATE_NONE;
         for (genvar i = 0; i < N_HOPS; i++) begin : g_hop
            rate_t hop;
            assign hop      = hop_rates[i*RATE_W +: RATE_W];
            assign run[i+1] = (hop < run[i]) ? hop : run[i];
         end
         assign slowest = run[N_HOPS];
      end
   endgenerate
endmodule

// File: rtl/rlm_cc_timer.sv
module rlm_cc_timer #(
   parameter int CC_PERIOD = 2048
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic tick,
   input  logic fire,
   output logic due
);
   localparam int CNT_W = $clog2(CC_PERIOD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CC_PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign due = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt_q <= '0;
      end else if (fire) begin
         cnt_q <= '0;
      end else if (tick && !due) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rlm_align_inserter.sv
module rlm_align_inserter
   import rlm_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                N_HOPS     = 4,
   parameter int                CC_PERIOD  = 2048,
   parameter logic [DATA_W-1:0] ALIGN_WORD = DATA_W'(32'hBC4A_4A7B)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     conn_start,
   input  logic [RATE_W-1:0]        tx_rate,
   input  logic [N_HOPS*RATE_W-1:0] path_rates,
   input  logic                     in_valid,
   input  logic [DATA_W-1:0]        in_data,
   output logic                     in_ready,
   output logic                     out_valid,
   output logic [DATA_W-1:0]        out_data,
   output logic                     out_align
);
   generate
      if (CC_PERIOD < 8) begin : g_bad_period
         $error("CC_PERIOD must be at least 8");
      end
      if (N_HOPS < 1) begin : g_bad_hops
         $error("N_HOPS must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic             active_q;
   logic [PAD_W-1:0] pad_k_q;
   logic [PAD_W-1:0] pad_left_q;
   rate_t            slowest;
   logic             cc_due;
   logic             emit_pad;
   logic             emit_cc;
   logic             take;
   logic             live;

   rlm_slowest_rate #(.N_HOPS(N_HOPS)) u_slowest (
      .hop_rates (path_rates),
      .slowest   (slowest)
   );

   assign live     = active_q & ~conn_start;
   assign emit_pad = live & (pad_left_q != '0);
   assign emit_cc  = live & (pad_left_q == '0) & cc_due;
   assign in_ready = live & (pad_left_q == '0) & ~cc_due;
   assign take     = in_valid & in_ready;

   rlm_cc_timer #(.CC_PERIOD(CC_PERIOD)) u_cc (
      .clk   (clk),
      .rst   (rst),
      .clear (conn_start),
      .tick  (emit_pad | take),
      .fire  (emit_cc),
      .due   (cc_due)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q   <= 1'b0;
         pad_k_q    <= '0;
         pad_left_q <= '0;
         out_valid  <= 1'b0;
         out_align  <= 1'b0;
         out_data   <= '0;
      end else if (conn_start) begin
         active_q   <= 1'b1;
         pad_k_q    <= pad_for(tx_rate, slowest);
         pad_left_q <= '0;
         out_valid  <= 1'b0;
         out_align  <= 1'b0;
         out_data   <= '0;
      end else begin
         out_valid <= emit_pad | emit_cc | take;
         out_align <= emit_pad | emit_cc;
         if (emit_pad || emit_cc) begin
            out_data <= ALIGN_WORD;
         end else if (take) begin
            out_data <= in_data;
         end else begin
            out_data <= '0;
         end
         if (emit_pad) begin
            pad_left_q <= pad_left_q - 1'b1;
         end else if (take) begin
            pad_left_q <= pad_k_q;
         end
      end
   end
endmodule

// File: rtl/rlm_align_inserter_chk.sv
module rlm_align_inserter_chk #(
   parameter int CC_PERIOD = 2048
) (
   input logic       clk,
   input logic       rst,
   input logic       conn_start,
   input logic       in_valid,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_align,
   input logic [1:0] pad_left,
   input logic [1:0] pad_k
);
   localparam int RUN_W = $clog2(CC_PERIOD + 1);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst || conn_start) begin
         run_q <= '0;
      end else if (out_valid && out_align) begin
         run_q <= '0;
      end else if (out_valid && run_q != RUN_W'(CC_PERIOD)) begin
         run_q <= run_q + 1'b1;
      end
   end

   assert_accept_to_out_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (out_valid && !out_align));

   assert_pending_pad_R3: assert property (@(posedge clk) disable iff (rst)
      (pad_left != 2'd0 && !conn_start) |=> (out_valid && out_align));

   assert_align_no_accept_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_align) |-> !$past(in_valid && in_ready));

   assert_cc_run_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_align) |-> (run_q < RUN_W'(CC_PERIOD - 1)));

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !conn_start |=> $stable(pad_k));

   assert_reset_idle_R8: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

bind rlm_align_inserter rlm_align_inserter_chk #(.CC_PERIOD(CC_PERIOD)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .conn_start (conn_start),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_align  (out_align),
   .pad_left   (pad_left_q),
   .pad_k      (pad_k_q)
);

// File: tb/rlm_align_inserter_tb_top.sv
module rlm_align_inserter_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          CC_P       = 64;
   localparam int          N_HOPS     = 4;
   localparam logic [31:0] ALIGN_W    = 32'hBC4A_4A7B;
   localparam logic [31:0] BASE       = 32'h1000_0000;
   localparam int          REC_MAX    = 512;

   logic        clk = 1'b0;
   logic        rst;
   logic        conn_start;
   logic [1:0]  tx_rate;
   logic [7:0]  path_rates;
   logic        in_valid;
   logic [31:0] in_data;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_align;

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;

   logic [31:0] rec_d  [REC_MAX];
   logic        rec_al [REC_MAX];
   int          rec_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   rlm_align_inserter #(
      .DATA_W(32), .N_HOPS(N_HOPS), .CC_PERIOD(CC_P), .ALIGN_WORD(ALIGN_W)
   ) dut_i (
      .clk(clk), .rst(rst), .conn_start(conn_start), .tx_rate(tx_rate),
      .path_rates(path_rates), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_align(out_align)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] hops(input int h3, input int h2, input int h1, input int h0);
      return {h3[1:0], h2[1:0], h1[1:0], h0[1:0]};
   endfunction

   task automatic do_start(input logic [1:0] tx, input logic [7:0] pr);
      @(negedge clk);
      tx_rate    = tx;
      path_rates = pr;
      conn_start = 1'b1;
      in_valid   = 1'b0;
      @(negedge clk);
      conn_start = 1'b0;
   endtask

   // Streams n dwords with valid held high, records every valid output
   task automatic run_stream(input int n, input int tail);
      int  sent   = 0;
      bit  acc    = 1'b0;
      int  idle   = 0;
      int  guard  = 0;
      rec_n = 0;
      while (idle < tail && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (out_valid && rec_n < REC_MAX) begin
            rec_d[rec_n]  = out_data;
            rec_al[rec_n] = out_align;
            rec_n++;
         end
         if (acc) sent++;
         in_valid = (sent < n);
         in_data  = BASE + 32'(sent);
         acc      = in_valid && in_ready;
         if (sent >= n) idle++;
      end
      in_valid = 1'b0;
   endtask

   // Each data dword d followed by k ALIGNs, k+1 after dword ext
   task automatic check_gaps(input int n, input int k, input int ext, input string req);
      int idx = 0;
      int bad_al = 0;
      for (int d = 0; d < n; d++) begin
         int cnt = 0;
         int exp_g;
         if (idx >= rec_n) begin
            chk(1'b0, req, "missing data dword", d, n);
            return;
         end
         chk(!rec_al[idx] && rec_d[idx] == BASE + 32'(d), req, "data order",
             rec_d[idx], BASE + 32'(d));
         idx++;
         while (idx < rec_n && rec_al[idx]) begin
            if (rec_d[idx] != ALIGN_W) bad_al++;
            cnt++;
            idx++;
         end
         exp_g = k + ((d == ext) ? 1 : 0);
         chk(cnt == exp_g, req, $sformatf("ALIGNs after dword %0d", d), cnt, exp_g);
      end
      chk(idx == rec_n, req, "extra output dwords", rec_n, idx);
      chk(bad_al == 0, req, "ALIGN pattern errors", bad_al, 0);
   endtask

   task automatic t_reset;
      rst = 1'b1; conn_start = 1'b0; in_valid = 1'b1; in_data = BASE;
      tx_rate = 2'd2; path_rates = 8'hFF;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b0, "R8", "in_ready before start", in_ready, 0);
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R8", "no output before start", out_valid, 0);
      in_valid = 1'b0;
   endtask

   task automatic t_pad_three;
      // R1 R2: 6.0 local, slowest hop 1.5 among absent/3.0 hops
      do_start(2'd2, hops(3, 1, 0, 3));
      run_stream(10, 8);
      check_gaps(10, 3, -1, "R2");
   endtask

   task automatic t_pad_one;
      // R1: min of 6.0, 3.0 with absent hops is 3.0 -> pad 1
      do_start(2'd2, hops(3, 3, 1, 2));
      run_stream(8, 6);
      check_gaps(8, 1, -1, "R1");
      // R2: 3.0 local over 1.5 -> pad 1
      do_start(2'd1, hops(3, 0, 3, 2));
      run_stream(6, 6);
      check_gaps(6, 1, -1, "R2");
   endtask

   task automatic t_pad_zero;
      // R2: local slower than path, and no hop present
      do_start(2'd0, hops(3, 3, 2, 1));
      run_stream(6, 6);
      check_gaps(6, 0, -1, "R2");
      do_start(2'd2, hops(3, 3, 3, 3));
      run_stream(5, 6);
      check_gaps(5, 0, -1, "R2");
   endtask

   task automatic t_cc_plain;
      int n = 2*CC_P + 5;
      int errs = 0;
      int d = 0;
      // R5: pad 0, compensation ALIGN at positions CC_P-1 and 2*CC_P-1
      do_start(2'd1, hops(3, 3, 2, 1));
      run_stream(n, 6);
      chk(rec_n == n + 2, "R5", "output count", rec_n, n + 2);
      for (int p = 0; p < rec_n; p++) begin
         bit exp_al = (p == CC_P - 1) || (p == 2*CC_P - 1);
         if (rec_al[p] != exp_al) errs++;
         else if (exp_al && rec_d[p] != ALIGN_W) errs++;
         else if (!exp_al) begin
            if (rec_d[p] != BASE + 32'(d)) errs++;
            d++;
         end
      end
      chk(errs == 0, "R5", "compensation slot/data mismatches", errs, 0);
      chk(d == n, "R4", "data dwords delivered", d, n);
   endtask

   task automatic t_cc_deferred;
      // R6: pad 3, compensation lands after dword (CC_P-2)/4
      do_start(2'd2, hops(0, 3, 3, 3));
      run_stream(30, 8);
      check_gaps(30, 3, (CC_P - 2) / 4, "R6");
   endtask

   task automatic t_cfg_hold;
      // R7: rates changed after start are ignored until the next start
      do_start(2'd2, hops(3, 3, 0, 3));
      tx_rate    = 2'd0;
      path_rates = hops(2, 2, 2, 2);
      run_stream(6, 6);
      check_gaps(6, 3, -1, "R7");
      do_start(2'd0, hops(2, 2, 2, 2));
      run_stream(6, 6);
      check_gaps(6, 0, -1, "R7");
   endtask

   initial begin
      t_reset();
      t_pad_three();
      t_pad_one();
      t_pad_zero();
      t_cc_plain();
      t_cc_deferred();
      t_cfg_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
         $finish;
      end
   end
endmodule